// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This core keeps the date and time in packed BCD: seconds, minutes, 24-hour hours, day of week, day of month, month, two-digit year and century. A hidden counter chain advances on each one-second tick. Every carry between fields, month lengths and leap years is handled inside the chain. The host never reads the counters directly. It sees a set of byte-wide shadow cells in the top sixteen addresses of a register window. One cycle after each tick, those cells are refreshed from the counters.

A control byte shares the same window and gives the host two gates. A freeze bit stops the refresh, so a multi-byte read is coherent while the counters keep running. A halt bit also stops the refresh and lets the host write new values into the shadow cells. Clearing the halt bit transfers those cells into the counters in a single cycle. The low bits of the control byte hold a calibration value that is stored but not acted on. While the power-good input is low, every host write is dropped.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, reads return seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00, century 20 and control 00.
- R2: Only addresses whose bits above bit 3 are all ones are decoded. Offsets: F seconds, E minutes, D hours, C day, B date, A month, 9 year, 8 control, 1 century. Every other address reads 00 and ignores writes. rd_data_o takes the selected byte on the clock edge that samples re_i, and holds it until the next read.
- R3: A tick sampled at one edge advances the counters by one second at that edge. The visible bytes take the new time at the following edge. Without a tick or a load, the counters hold.
- R4: Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and advance both the day and the date.
- R5: The day of week counts 1 to 7 and wraps to 1.
- R6: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. February ends after 28, or after 29 when the BCD year is divisible by 4 (00 included).
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century in BCD. Century 99 wraps to 00.
- R8: Control bit 6 set blocks the refresh, so the visible bytes hold while the counters keep counting. After it clears, the next tick refresh shows every tick that occurred.
- R9: Control bit 7 set blocks the refresh and keeps the host's time writes. Writing the control byte with bit 7 clear while it is set loads all visible time bytes into the counters. A time write with bit 7 clear reaches only the visible cell, and the next refresh overwrites it.
- R10: Control bits 4:0 are stored and read back and have no effect on timing. Bit 5 always reads 0.
- R11: While pwr_ok_i is low, no host write changes any register. Reads still work.
- R12: Written values are masked before they are stored: seconds and minutes 7F, hours 3F, day 07, date 3F, month 1F. Year, century and control bits 7:6 and 4:0 are kept whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse each second |
| pwr_ok_i | input | 1 | Supply in tolerance; low blocks writes |
| addr_i | input | ADDR_W | Byte address in the register window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |

## Verification
The hardest states to reach are the far ends of the carry chain: February 29 in a leap year, the year-99 rollover into the century and the century wrapping itself. Counting up to them from reset would take millions of ticks. The bench instead uses the halt-and-load path to place the counters one second before each boundary, then applies a single tick. The freeze case also needs care, because the hidden counters can only be seen once the freeze is lifted. The bench therefore checks that the first refresh after the freeze shows all the ticks applied while frozen.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [3:0] OFF_SEC   = 4'hF;
  localparam logic [3:0] OFF_MIN   = 4'hE;
  localparam logic [3:0] OFF_HOUR  = 4'hD;
  localparam logic [3:0] OFF_DAY   = 4'hC;
  localparam logic [3:0] OFF_DATE  = 4'hB;
  localparam logic [3:0] OFF_MONTH = 4'hA;
  localparam logic [3:0] OFF_YEAR  = 4'h9;
  localparam logic [3:0] OFF_CTRL  = 4'h8;
  localparam logic [3:0] OFF_CENT  = 4'h1;

  localparam int CTRL_HALT   = 7;
  localparam int CTRL_FREEZE = 6;
  localparam logic [7:0] CTRL_MASK = 8'hDF;

  localparam rtc_time_t TIME_RST = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                     date: 8'h01, day: 8'h01, hour: 8'h00,
                                     min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction

  // BCD year divisible by 4: odd tens need ones 2/6, even tens need 0/4/8
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);
  rtc_time_t cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (cnt_q.sec != 8'h59) cnt_nxt.sec = bcd_inc(cnt_q.sec);
    else begin
      cnt_nxt.sec = 8'h00;
      if (cnt_q.min != 8'h59) cnt_nxt.min = bcd_inc(cnt_q.min);
      else begin
        cnt_nxt.min = 8'h00;
        if (cnt_q.hour != 8'h23) cnt_nxt.hour = bcd_inc(cnt_q.hour);
        else begin
          cnt_nxt.hour = 8'h00;
          cnt_nxt.day  = (cnt_q.day >= 8'h07) ? 8'h01 : cnt_q.day + 8'd1;
          if (cnt_q.date < last_date(cnt_q.month, cnt_q.year))
            cnt_nxt.date = bcd_inc(cnt_q.date);
          else begin
            cnt_nxt.date = 8'h01;
            if (cnt_q.month != 8'h12) cnt_nxt.month = bcd_inc(cnt_q.month);
            else begin
              cnt_nxt.month = 8'h01;
              if (cnt_q.year != 8'h99) cnt_nxt.year = bcd_inc(cnt_q.year);
              else begin
                cnt_nxt.year = 8'h00;
                cnt_nxt.cent = (cnt_q.cent == 8'h99) ? 8'h00 : bcd_inc(cnt_q.cent);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= TIME_RST;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt_q));
  assert_load_transfer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_dow_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !load_i && cnt_q.day == 8'h07 && cnt_q.hour == 8'h23 &&
    cnt_q.min == 8'h59 && cnt_q.sec == 8'h59 |=> cnt_q.day == 8'h01);
  assert_sec_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !load_i && cnt_q.sec == 8'h59 |=> cnt_q.sec == 8'h00);
endmodule

// File: rtl/rtc_reg_file.sv
module rtc_reg_file
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok_i,
  input  logic       sel_i,
  input  logic [3:0] off_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       re_i,
  input  logic       refresh_i,
  input  rtc_time_t  cnt_i,
  output rtc_time_t  vis_o,
  output logic       load_o,
  output logic [7:0] rd_data_o
);
  rtc_time_t  vis_q;
  logic [7:0] ctrl_q, rd_mux;
  logic       wr_ok, do_refresh;

  assign wr_ok      = we_i && sel_i && pwr_ok_i;
  assign do_refresh = refresh_i && !ctrl_q[CTRL_FREEZE] && !ctrl_q[CTRL_HALT];
  assign load_o     = wr_ok && (off_i == OFF_CTRL) && ctrl_q[CTRL_HALT] && !wdata_i[CTRL_HALT];

  always_comb begin
    rd_mux = 8'h00;
    if (sel_i) begin
      case (off_i)
        OFF_SEC:   rd_mux = vis_q.sec;
        OFF_MIN:   rd_mux = vis_q.min;
        OFF_HOUR:  rd_mux = vis_q.hour;
        OFF_DAY:   rd_mux = vis_q.day;
        OFF_DATE:  rd_mux = vis_q.date;
        OFF_MONTH: rd_mux = vis_q.month;
        OFF_YEAR:  rd_mux = vis_q.year;
        OFF_CTRL:  rd_mux = ctrl_q;
        OFF_CENT:  rd_mux = vis_q.cent;
        default:   rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q     <= TIME_RST;
      ctrl_q    <= 8'h00;
      rd_data_o <= 8'h00;
    end else begin
      if (wr_ok && off_i == OFF_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (do_refresh) vis_q <= cnt_i;
      else if (wr_ok) begin
        case (off_i)
          OFF_SEC:   vis_q.sec   <= wdata_i & 8'h7F;
          OFF_MIN:   vis_q.min   <= wdata_i & 8'h7F;
          OFF_HOUR:  vis_q.hour  <= wdata_i & 8'h3F;
          OFF_DAY:   vis_q.day   <= wdata_i & 8'h07;
          OFF_DATE:  vis_q.date  <= wdata_i & 8'h3F;
          OFF_MONTH: vis_q.month <= wdata_i & 8'h1F;
          OFF_YEAR:  vis_q.year  <= wdata_i;
          OFF_CENT:  vis_q.cent  <= wdata_i;
          default:   ;
        endcase
      end
      if (re_i) rd_data_o <= rd_mux;
    end
  end

  assign vis_o = vis_q;

  assert_no_write_unpowered_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i && !refresh_i |=> $stable(vis_q) && $stable(ctrl_q));
  assert_freeze_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_FREEZE] && !we_i |=> $stable(vis_q));
  assert_halt_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_HALT] && !we_i |=> $stable(vis_q));
  assert_read_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rd_data_o));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwr_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  output logic [7:0]        rd_data_o
);
  localparam int OFF_W = 4;

  rtc_time_t cnt, vis;
  logic      load, tick_q, sel;

  assign sel = &addr_i[ADDR_W-1:OFF_W];

  // refresh trails the counter update by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_i;
  end

  rtc_time_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (vis),
    .cnt_o      (cnt)
  );

  rtc_reg_file u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_ok_i  (pwr_ok_i),
    .sel_i     (sel),
    .off_i     (addr_i[OFF_W-1:0]),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .re_i      (re_i),
    .refresh_i (tick_q),
    .cnt_i     (cnt),
    .vis_o     (vis),
    .load_o    (load),
    .rd_data_o (rd_data_o)
  );

  assert_ctrl_bit5_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && sel && addr_i[OFF_W-1:0] == OFF_CTRL |=> !rd_data_o[5]);
  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !sel |=> rd_data_o == 8'h00);
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  localparam int ADDR_W = 19;
  localparam logic [ADDR_W-1:0] A_SEC = 19'h7FFFF, A_MIN = 19'h7FFFE, A_HOUR = 19'h7FFFD,
    A_DAY = 19'h7FFFC, A_DATE = 19'h7FFFB, A_MON = 19'h7FFFA, A_YEAR = 19'h7FFF9,
    A_CTRL = 19'h7FFF8, A_CENT = 19'h7FFF1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_ok = 1'b1, we = 1'b0, re = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 8'h00, rd_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwr_ok_i(pwr_ok),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .re_i(re), .rd_data_o(rd_data));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s addr %h: actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, dt, dy, h, mi, s);
    wr(A_CTRL, 8'h80);
    wr(A_CENT, c); wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, dt);
    wr(A_DAY, dy); wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_reset();
    chk(A_SEC, 8'h00, "R1"); chk(A_MIN, 8'h00, "R1"); chk(A_HOUR, 8'h00, "R1");
    chk(A_DAY, 8'h01, "R1"); chk(A_DATE, 8'h01, "R1"); chk(A_MON, 8'h01, "R1");
    chk(A_YEAR, 8'h00, "R1"); chk(A_CENT, 8'h20, "R1"); chk(A_CTRL, 8'h00, "R1");
  endtask

  task automatic t_basic_tick();
    set_time(8'h20, 8'h25, 8'h03, 8'h14, 8'h05, 8'h12, 8'h34, 8'h56);
    do_tick();
    chk(A_SEC, 8'h57, "R3"); chk(A_MIN, 8'h34, "R3");
    do_tick(); do_tick(); do_tick();
    chk(A_SEC, 8'h00, "R4"); chk(A_MIN, 8'h35, "R4");
  endtask

  task automatic t_day_roll();
    set_time(8'h20, 8'h25, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
    do_tick();
    chk(A_HOUR, 8'h00, "R4"); chk(A_DATE, 8'h16, "R4");
    chk(A_DAY, 8'h01, "R5"); chk(A_MON, 8'h06, "R4");
  endtask

  task automatic month_end(input logic [7:0] y, mo, dt, emo, edt);
    set_time(8'h20, y, mo, dt, 8'h02, 8'h23, 8'h59, 8'h59);
    do_tick();
    chk(A_DATE, edt, "R6"); chk(A_MON, emo, "R6");
  endtask

  task automatic t_months();
    month_end(8'h25, 8'h04, 8'h30, 8'h05, 8'h01);
    month_end(8'h25, 8'h01, 8'h30, 8'h01, 8'h31);
    month_end(8'h25, 8'h01, 8'h31, 8'h02, 8'h01);
    month_end(8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end(8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end(8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    month_end(8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end(8'h16, 8'h02, 8'h28, 8'h02, 8'h29);
    month_end(8'h26, 8'h02, 8'h28, 8'h03, 8'h01);
    month_end(8'h25, 8'h11, 8'h30, 8'h12, 8'h01);
  endtask

  task automatic t_year_end();
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
    do_tick();
    chk(A_YEAR, 8'h00, "R7"); chk(A_CENT, 8'h20, "R7");
    chk(A_MON, 8'h01, "R7"); chk(A_DATE, 8'h01, "R7");
    set_time(8'h99, 8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
    do_tick();
    chk(A_CENT, 8'h00, "R7");
    set_time(8'h20, 8'h49, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
    do_tick();
    chk(A_YEAR, 8'h50, "R7"); chk(A_CENT, 8'h20, "R7");
  endtask

  task automatic t_freeze();
    set_time(8'h20, 8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h00, 8'h10);
    wr(A_CTRL, 8'h40);
    do_tick(); do_tick(); do_tick();
    chk(A_SEC, 8'h10, "R8"); chk(A_CTRL, 8'h40, "R8");
    wr(A_CTRL, 8'h00);
    chk(A_SEC, 8'h10, "R8");
    do_tick();
    chk(A_SEC, 8'h14, "R8");
  endtask

  task automatic t_halt();
    set_time(8'h20, 8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h00, 8'h10);
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h40);
    do_tick(); do_tick();
    chk(A_SEC, 8'h40, "R9");
    wr(A_CTRL, 8'h00);
    do_tick();
    chk(A_SEC, 8'h41, "R9");
    wr(A_SEC, 8'h05);
    chk(A_SEC, 8'h05, "R9");
    do_tick();
    chk(A_SEC, 8'h42, "R9");
  endtask

  task automatic t_calib();
    set_time(8'h20, 8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h00, 8'h20);
    wr(A_CTRL, 8'h3F);
    chk(A_CTRL, 8'h1F, "R10");
    do_tick();
    chk(A_SEC, 8'h21, "R10");
    wr(A_CTRL, 8'h15);
    chk(A_CTRL, 8'h15, "R10");
    do_tick();
    chk(A_SEC, 8'h22, "R10");
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_power();
    set_time(8'h20, 8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h00, 8'h30);
    pwr_ok = 1'b0;
    wr(A_SEC, 8'h11); wr(A_CTRL, 8'h80); wr(A_CENT, 8'h33);
    chk(A_SEC, 8'h30, "R11"); chk(A_CTRL, 8'h00, "R11"); chk(A_CENT, 8'h20, "R11");
    do_tick();
    chk(A_SEC, 8'h31, "R11");
    pwr_ok = 1'b1;
  endtask

  task automatic t_masks();
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'hFF); wr(A_MIN, 8'hFF); wr(A_HOUR, 8'hFF);
    wr(A_DAY, 8'hFF); wr(A_DATE, 8'hFF); wr(A_MON, 8'hFF); wr(A_YEAR, 8'hFF);
    chk(A_SEC, 8'h7F, "R12"); chk(A_MIN, 8'h7F, "R12"); chk(A_HOUR, 8'h3F, "R12");
    chk(A_DAY, 8'h07, "R12"); chk(A_DATE, 8'h3F, "R12"); chk(A_MON, 8'h1F, "R12");
    chk(A_YEAR, 8'hFF, "R12");
    set_time(8'h20, 8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h00, 8'h00);
  endtask

  task automatic t_addr();
    wr(19'h7FFF5, 8'hAA);
    chk(19'h7FFF5, 8'h00, "R2");
    wr(19'h3FFFF, 8'h45);
    chk(19'h3FFFF, 8'h00, "R2");
    chk(A_SEC, 8'h00, "R2");
    chk(A_MIN, 8'h00, "R2");
    @(negedge clk); addr = A_SEC;
    @(negedge clk);
    n_chk++;
    if (rd_data !== 8'h00) begin
      n_fail++;
      $display("FAIL R2 read hold: actual %h expected %h", rd_data, 8'h00);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_tick();
    t_day_roll();
    t_months();
    t_year_end();
    t_freeze();
    t_halt();
    t_calib();
    t_power();
    t_masks();
    t_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule